// File: doc/BRIEF.md
# Microprogram Sequencer with Opcode Decode Mapping

This block produces the control-store address for a horizontally microcoded 32-bit RISC controller. It holds an 11-bit address register (2048 microwords of 41 bits each) and a separate register that carries the address plus one. At each falling clock edge it loads one of three sources into the address register. The first is the incremented address. The second is an 11-bit jump target taken from the current microword. The third is a decode address formed from the opcode fields of the instruction word.

The microword supplies a 3-bit condition selector and the jump target. The datapath supplies the four status flags (negative, zero, overflow, carry) and the instruction word. The memory interface supplies the read and write strobes of the current microword and the acknowledge. The sequencer freezes while a memory access is still waiting for its acknowledge. An all-ones instruction word is mapped to the reserved address 2044, and a halt output is raised while that address is held. The control store and the datapath sit outside this block.

Top module: `useq_addr_gen`

## Requirements
- R1: While `rst_n` is low at a falling clock edge, the address becomes 0 and `halt` becomes 0.
- R2: Condition code 0 (never) loads the current address plus one, modulo 2048, so 2047 is followed by 0.
- R3: Condition codes 1, 2, 3, 4 and 5 test the n, z, v and c flags and instruction bit 13, in that order. When the tested bit is 1, the jump field is loaded. Otherwise the current address plus one is loaded.
- R4: Condition code 6 (always) loads the 11-bit jump field whatever the flags are.
- R5: Condition code 7 (decode) with OP = instr[31:30] = 00 loads {1,0,0, instr[24:22], 00000}. The remaining bits of the word, including the 22-bit immediate, have no effect on this address.
- R6: Condition code 7 with OP = 01 loads 1280 (binary 10100000000) whatever the other instruction bits are.
- R7: Condition code 7 with OP = 10 or 11 loads {1, OP, instr[24:19], 00}.
- R8: When (rd and not ack) or (wr and not ack) holds, the address, `halt` and the incremented value are all left unchanged, whatever the condition code is. When the access is acknowledged, the sequence continues from the held address.
- R9: A decode of the all-ones instruction word loads 2044 and sets `halt`. `halt` falls at the next load through any path. A jump to 2044 through the jump field does not set `halt`.
- R10: The outputs change only at falling clock edges. They hold their value across a rising edge, including when the inputs change there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates happen on the falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cond_sel | input | 3 | Jump-condition field of the current microword |
| jump_addr | input | 11 | Jump-target field of the current microword |
| flag_n | input | 1 | Negative status flag |
| flag_z | input | 1 | Zero status flag |
| flag_v | input | 1 | Overflow status flag |
| flag_c | input | 1 | Carry status flag |
| instr | input | 32 | Instruction register contents |
| mem_rd | input | 1 | Read strobe of the current microword |
| mem_wr | input | 1 | Write strobe of the current microword |
| mem_ack | input | 1 | Memory acknowledge |
| cs_addr | output | 11 | Control-store address |
| halt | output | 1 | High while the address came from decoding the all-ones word |

## Verification
The bench builds the block with its default parameters: reset address 0 and instruction bit 13 as the tested bit. This makes every condition code, every OP pattern and the 2047-to-0 wrap reachable within a short run. Directed steps cover each flag both true and false, and decode words that differ only in their immediate bits. They also cover the halt word, a jump to 2044 through the jump field, and stalls caused by read, by write and by both strobes together. Seeded random microwords, flags and instruction words, with frequent stalls, then run the sequence against a reference model in the bench.

// File: rtl/useq_pkg.sv
// Package: shared constants and encodings for the microprogram sequencer.
// Assumes a fixed 11-bit control-store address, which the decode mapping needs.
package useq_pkg;

    localparam int CS_ADDR_W = 11;
    localparam int INSTR_W   = 32;
    localparam int COND_W    = 3;

    // Opcode field positions inside the instruction word
    localparam int OP_HI  = 31;
    localparam int OP_LO  = 30;
    localparam int OP2_HI = 24;
    localparam int OP2_LO = 22;
    localparam int OP3_HI = 24;
    localparam int OP3_LO = 19;

    // Reserved address reached by decoding the all-ones word
    localparam logic [CS_ADDR_W-1:0] HALT_ADDR = 11'd2044;
    // Fixed entry used for OP = 01
    localparam logic [CS_ADDR_W-1:0] CALL_ADDR = 11'b101_0000_0000;

    typedef enum logic [COND_W-1:0] {
        COND_NEVER  = 3'd0,
        COND_NEG    = 3'd1,
        COND_ZERO   = 3'd2,
        COND_OVF    = 3'd3,
        COND_CARRY  = 3'd4,
        COND_IRBIT  = 3'd5,
        COND_ALWAYS = 3'd6,
        COND_DECODE = 3'd7
    } cond_e;

    typedef enum logic [1:0] {
        SRC_INC    = 2'd0,
        SRC_JUMP   = 2'd1,
        SRC_DECODE = 2'd2
    } src_e;

endpackage

// File: rtl/useq_decode_map.sv
// Module: maps instruction opcode fields to a control-store entry address.
// Assumes the field positions in useq_pkg. Purely combinational. Branch and
// SETHI share one entry, so the immediate bits never take part.
module useq_decode_map
    import useq_pkg::*;
(
    input  logic [INSTR_W-1:0]   instr,
    output logic [CS_ADDR_W-1:0] dec_addr,
    output logic                 halt_word
);

    logic [1:0]             op;
    logic [OP2_HI-OP2_LO:0] op2;
    logic [OP3_HI-OP3_LO:0] op3;

    assign op  = instr[OP_HI:OP_LO];
    assign op2 = instr[OP2_HI:OP2_LO];
    assign op3 = instr[OP3_HI:OP3_LO];

    // Purpose: build the entry address from OP, OP2 and OP3.
    always_comb begin
        unique case (op)
            2'b00:   dec_addr = {3'b100, op2, 5'b00000};
            2'b01:   dec_addr = CALL_ADDR;
            default: dec_addr = {1'b1, op, op3, 2'b00};
        endcase
    end

    // Purpose: detect the all-ones halt word.
    assign halt_word = &instr;

endmodule

// File: rtl/useq_cond_eval.sv
// Module: evaluates the microword condition field against the status flags.
// Assumes the cond_e encoding. Produces a jump request and a decode request.
module useq_cond_eval
    import useq_pkg::*;
(
    input  logic [COND_W-1:0] cond_sel,
    input  logic              flag_n,
    input  logic              flag_z,
    input  logic              flag_v,
    input  logic              flag_c,
    input  logic              ir_bit,
    output logic              take_jump,
    output logic              take_decode
);

    // Purpose: select the tested condition and classify the requested path.
    always_comb begin
        take_jump   = 1'b0;
        take_decode = 1'b0;
        unique case (cond_e'(cond_sel))
            COND_NEVER:  take_jump = 1'b0;
            COND_NEG:    take_jump = flag_n;
            COND_ZERO:   take_jump = flag_z;
            COND_OVF:    take_jump = flag_v;
            COND_CARRY:  take_jump = flag_c;
            COND_IRBIT:  take_jump = ir_bit;
            COND_ALWAYS: take_jump = 1'b1;
            COND_DECODE: take_decode = 1'b1;
            default:     take_jump = 1'b0;
        endcase
    end

endmodule

// File: rtl/useq_next_sel.sv
// Module: picks the next address source and the next halt value.
// Assumes take_jump and take_decode are never both set. Combinational.
module useq_next_sel
    import useq_pkg::*;
(
    input  logic                 take_jump,
    input  logic                 take_decode,
    input  logic                 halt_word,
    input  logic [CS_ADDR_W-1:0] inc_addr,
    input  logic [CS_ADDR_W-1:0] jump_addr,
    input  logic [CS_ADDR_W-1:0] dec_addr,
    output src_e                 src,
    output logic [CS_ADDR_W-1:0] nxt_addr,
    output logic                 nxt_halt
);

    // Purpose: priority encode the source; decode wins over jump.
    always_comb begin
        if (take_decode)    src = SRC_DECODE;
        else if (take_jump) src = SRC_JUMP;
        else                src = SRC_INC;
    end

    // Purpose: steer the chosen source onto the next-address bus.
    always_comb begin
        unique case (src)
            SRC_DECODE: nxt_addr = dec_addr;
            SRC_JUMP:   nxt_addr = jump_addr;
            default:    nxt_addr = inc_addr;
        endcase
    end

    // Purpose: halt is only raised by decoding the all-ones word.
    assign nxt_halt = (src == SRC_DECODE) && halt_word;

endmodule

// File: rtl/useq_inc_reg.sv
// Module: registered address incrementer, loaded with next address plus one.
// Assumes falling-edge clocking and synchronous active-low reset. Holding
// this value in a register keeps the increment path free of combinational loops.
module useq_inc_reg
    import useq_pkg::*;
#(
    parameter logic [CS_ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_en,
    input  logic [CS_ADDR_W-1:0] nxt_addr,
    output logic [CS_ADDR_W-1:0] inc_addr
);

    localparam logic [CS_ADDR_W-1:0] ONE = {{(CS_ADDR_W-1){1'b0}}, 1'b1};

    // Purpose: capture next address plus one whenever the sequencer advances.
    always_ff @(negedge clk) begin
        if (!rst_n)       inc_addr <= RESET_ADDR + ONE;
        else if (load_en) inc_addr <= nxt_addr + ONE;
    end

endmodule

// File: rtl/useq_addr_gen.sv
// Module: top of the microprogram sequencer. Holds the control-store address
// and the halt flag, and stalls while a memory strobe waits for its acknowledge.
// Assumes falling-edge clocking, synchronous active-low reset, and one
// microword per cycle coming from the current address.
module useq_addr_gen
    import useq_pkg::*;
#(
    parameter logic [CS_ADDR_W-1:0] RESET_ADDR  = '0,
    parameter int                   IR_TEST_BIT = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [COND_W-1:0]    cond_sel,
    input  logic [CS_ADDR_W-1:0] jump_addr,
    input  logic                 flag_n,
    input  logic                 flag_z,
    input  logic                 flag_v,
    input  logic                 flag_c,
    input  logic [INSTR_W-1:0]   instr,
    input  logic                 mem_rd,
    input  logic                 mem_wr,
    input  logic                 mem_ack,
    output logic [CS_ADDR_W-1:0] cs_addr,
    output logic                 halt
);

    localparam logic [CS_ADDR_W-1:0] ONE = {{(CS_ADDR_W-1){1'b0}}, 1'b1};

    logic                 take_jump;
    logic                 take_decode;
    logic                 halt_word;
    logic                 stall;
    logic                 load_en;
    src_e                 src;
    logic [CS_ADDR_W-1:0] dec_addr;
    logic [CS_ADDR_W-1:0] inc_addr;
    logic [CS_ADDR_W-1:0] nxt_addr;
    logic                 nxt_halt;
    logic [CS_ADDR_W-1:0] addr_q;
    logic                 halt_q;

    useq_decode_map u_decode (
        .instr     (instr),
        .dec_addr  (dec_addr),
        .halt_word (halt_word)
    );

    useq_cond_eval u_cond (
        .cond_sel    (cond_sel),
        .flag_n      (flag_n),
        .flag_z      (flag_z),
        .flag_v      (flag_v),
        .flag_c      (flag_c),
        .ir_bit      (instr[IR_TEST_BIT]),
        .take_jump   (take_jump),
        .take_decode (take_decode)
    );

    useq_next_sel u_sel (
        .take_jump   (take_jump),
        .take_decode (take_decode),
        .halt_word   (halt_word),
        .inc_addr    (inc_addr),
        .jump_addr   (jump_addr),
        .dec_addr    (dec_addr),
        .src         (src),
        .nxt_addr    (nxt_addr),
        .nxt_halt    (nxt_halt)
    );

    useq_inc_reg #(.RESET_ADDR(RESET_ADDR)) u_inc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .nxt_addr (nxt_addr),
        .inc_addr (inc_addr)
    );

    // Purpose: an unacknowledged read or write freezes the whole sequencer.
    assign stall   = (mem_rd && !mem_ack) || (mem_wr && !mem_ack);
    assign load_en = !stall;

    // Purpose: hold the control-store address and halt flag.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            addr_q <= RESET_ADDR;
            halt_q <= 1'b0;
        end else if (load_en) begin
            addr_q <= nxt_addr;
            halt_q <= nxt_halt;
        end
    end

    assign cs_addr = addr_q;
    assign halt    = halt_q;

    // R8: a stalled access leaves address and halt untouched
    assert_hold_R8: assert property (@(negedge clk) disable iff (!rst_n)
        ((mem_rd || mem_wr) && !mem_ack) |=> ($stable(cs_addr) && $stable(halt)));

    // R2: the never condition steps by one, wrapping at the top
    assert_step_R2: assert property (@(negedge clk) disable iff (!rst_n)
        (cond_sel == 3'd0 && !((mem_rd || mem_wr) && !mem_ack))
        |=> (cs_addr == $past(cs_addr) + ONE));

    // R4: the always condition takes the microword target
    assert_jump_R4: assert property (@(negedge clk) disable iff (!rst_n)
        (cond_sel == 3'd6 && !((mem_rd || mem_wr) && !mem_ack))
        |=> (cs_addr == $past(jump_addr) && !halt));

    // R6: OP = 01 decodes to the fixed entry
    assert_call_R6: assert property (@(negedge clk) disable iff (!rst_n)
        (cond_sel == 3'd7 && instr[31:30] == 2'b01 && !((mem_rd || mem_wr) && !mem_ack))
        |=> (cs_addr == CALL_ADDR));

    // R9: halt is only seen at the reserved address
    assert_halt_R9: assert property (@(negedge clk) disable iff (!rst_n)
        halt |-> (cs_addr == HALT_ADDR));

endmodule

// File: tb/useq_addr_gen_tb.sv
// Bench: directed corner cases plus seeded random microwords, checked
// against a reference model written from the requirements.
module useq_addr_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  cond_sel;
    logic [10:0] jump_addr;
    logic        flag_n, flag_z, flag_v, flag_c;
    logic [31:0] instr;
    logic        mem_rd, mem_wr, mem_ack;
    logic [10:0] cs_addr;
    logic        halt;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [10:0] exp_addr;
    logic        exp_halt;

    always #5 clk = ~clk;

    useq_addr_gen dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cond_sel  (cond_sel),
        .jump_addr (jump_addr),
        .flag_n    (flag_n),
        .flag_z    (flag_z),
        .flag_v    (flag_v),
        .flag_c    (flag_c),
        .instr     (instr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_ack   (mem_ack),
        .cs_addr   (cs_addr),
        .halt      (halt)
    );

    // Reference decode mapping, written from R5 to R7
    function automatic logic [10:0] ref_decode(input logic [31:0] w);
        case (w[31:30])
            2'b00:   return {3'b100, w[24:22], 5'd0};
            2'b01:   return 11'd1280;
            default: return {1'b1, w[31:30], w[24:19], 2'b00};
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One microcycle: drive after a rising edge, check after the falling edge
    task automatic step(input logic rst, input logic [2:0] c, input logic [10:0] ja,
                        input logic [3:0] fl, input logic [31:0] w,
                        input logic rd, input logic wr, input logic ack, input string req);
        logic       stl;
        logic       hit;
        @(posedge clk);
        #1;
        rst_n = rst; cond_sel = c; jump_addr = ja;
        {flag_n, flag_z, flag_v, flag_c} = fl;
        instr = w; mem_rd = rd; mem_wr = wr; mem_ack = ack;
        #1;
        chk("R10 addr stable over rising edge", 32'(cs_addr), 32'(exp_addr));
        stl = (rd && !ack) || (wr && !ack);
        if (!rst) begin
            exp_addr = 11'd0; exp_halt = 1'b0;
        end else if (!stl) begin
            exp_halt = 1'b0;
            case (c)
                3'd0: exp_addr = exp_addr + 11'd1;
                3'd6: exp_addr = ja;
                3'd7: begin exp_addr = ref_decode(w); exp_halt = (w == 32'hFFFF_FFFF); end
                default: begin
                    case (c)
                        3'd1: hit = fl[3];
                        3'd2: hit = fl[2];
                        3'd3: hit = fl[1];
                        3'd4: hit = fl[0];
                        default: hit = w[13];
                    endcase
                    exp_addr = hit ? ja : exp_addr + 11'd1;
                end
            endcase
        end
        @(negedge clk);
        #2;
        chk(req, 32'(cs_addr), 32'(exp_addr));
        chk({req, " halt"}, 32'(halt), 32'(exp_halt));
    endtask

    initial begin
        int unsigned seed;
        logic [31:0] w;
        seed = 32'd12345;
        void'($urandom(seed));
        rst_n = 1'b0; cond_sel = '0; jump_addr = '0; {flag_n, flag_z, flag_v, flag_c} = '0;
        instr = '0; mem_rd = 1'b0; mem_wr = 1'b0; mem_ack = 1'b0;
        exp_addr = 11'd0; exp_halt = 1'b0;

        // R1: reset state
        step(0, 3'd6, 11'd77, 4'h0, 32'h0, 0, 0, 0, "R1 reset");
        step(0, 3'd7, 11'd5, 4'hF, 32'hFFFF_FFFF, 0, 0, 1, "R1 reset held");
        // R2: increment and wrap
        step(1, 3'd0, 11'd9, 4'hF, 32'h0, 0, 0, 0, "R2 next");
        step(1, 3'd0, 11'd9, 4'h0, 32'h0, 0, 0, 0, "R2 next again");
        step(1, 3'd6, 11'd2047, 4'h0, 32'h0, 0, 0, 0, "R4 jump to top");
        step(1, 3'd0, 11'd5, 4'h0, 32'h0, 0, 0, 0, "R2 wrap to zero");
        // R3: each flag true and false
        for (int k = 1; k <= 4; k++) begin
            step(1, 3'(k), 11'(100 + k), 4'(1 << (4 - k)), 32'h0, 0, 0, 0, "R3 flag true");
            step(1, 3'(k), 11'(200 + k), 4'hF ^ 4'(1 << (4 - k)), 32'h0, 0, 0, 0, "R3 flag false");
        end
        step(1, 3'd5, 11'd321, 4'h0, 32'h0000_2000, 0, 0, 0, "R3 instr bit 13 set");
        step(1, 3'd5, 11'd322, 4'hF, 32'hFFFF_DFFF, 0, 0, 0, "R3 instr bit 13 clear");
        // R5: immediate bits ignored
        step(1, 3'd7, 11'd0, 4'h0, 32'h01C0_0000, 0, 0, 0, "R5 decode op00 imm0");
        step(1, 3'd7, 11'd0, 4'h0, 32'h01FF_FFFF, 0, 0, 0, "R5 decode op00 imm ones");
        step(1, 3'd7, 11'd0, 4'h0, 32'h3E80_1234, 0, 0, 0, "R5 decode op00 other op2");
        // R6, R7
        step(1, 3'd7, 11'd3, 4'hF, 32'h7FFF_FFFF, 0, 0, 0, "R6 decode op01");
        step(1, 3'd7, 11'd3, 4'h0, 32'h8068_0000, 0, 0, 0, "R7 decode op10");
        step(1, 3'd7, 11'd3, 4'h0, 32'hC028_0000, 0, 0, 0, "R7 decode op11");
        // R9: halt word, clear, jump field to 2044 without halt
        step(1, 3'd7, 11'd3, 4'h0, 32'hFFFF_FFFF, 0, 0, 0, "R9 halt decode");
        step(1, 3'd0, 11'd3, 4'h0, 32'hFFFF_FFFF, 0, 0, 0, "R9 halt clears");
        step(1, 3'd6, 11'd2044, 4'h0, 32'hFFFF_FFFF, 0, 0, 0, "R9 jump to 2044 no halt");
        step(1, 3'd7, 11'd3, 4'h0, 32'hFFFF_FFFF, 0, 0, 0, "R9 halt again");
        // R8: stall holds halt and address, for rd, wr and both
        step(1, 3'd6, 11'd55, 4'hF, 32'h0, 1, 0, 0, "R8 rd stall");
        step(1, 3'd7, 11'd55, 4'hF, 32'h0, 0, 1, 0, "R8 wr stall");
        step(1, 3'd0, 11'd55, 4'hF, 32'h0, 1, 1, 0, "R8 rd wr stall");
        step(1, 3'd0, 11'd55, 4'hF, 32'h0, 1, 0, 1, "R8 rd acked resumes");
        step(1, 3'd6, 11'd600, 4'h0, 32'h0, 0, 0, 0, "R4 jump");
        step(1, 3'd0, 11'd0, 4'h0, 32'h0, 0, 1, 0, "R8 stall before next");
        step(1, 3'd0, 11'd0, 4'h0, 32'h0, 0, 1, 1, "R8 next continues from held");
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] c;
            logic       rd, wr, ack;
            c = 3'($urandom);
            w = $urandom;
            if ($urandom % 8 == 0) w = 32'hFFFF_FFFF;
            rd = ($urandom % 4 == 0);
            wr = ($urandom % 4 == 0);
            ack = ($urandom % 2 == 0);
            step(($urandom % 200) != 0, c, 11'($urandom), 4'($urandom), w, rd, wr, ack,
                 "R3 R4 R7 R8 random");
        end
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule